// File: doc/BRIEF.md
# Syllable Fetch and Interrupt Injection Sequencer

This block feeds a stack processor's execution stage with 12-bit instruction syllables. Four syllables are packed into each 48-bit program word, and the first syllable sits in the most significant bits. The sequencer holds four registers: the current program word, a syllable index, the word address and the syllable now being executed. Each time execution reports that a syllable is complete, the sequencer loads the next syllable. When the word is used up, it steps the address and reads the following word over a simple request/acknowledge memory port.

An interrupt can be pending while the processor is in normal state. In that case a fixed store-for-interrupt syllable (0x609) is put in place of the next syllable, the syllable index and the address stay where they are, and the hardware-induced interrupt flag is raised. The block also reports the major class of the current syllable. It carries out the two dial operators and the temporary full-addressing operator that shares their encoding space. It also emits the per-syllable clear strobes for the serial and character-mode registers that are held elsewhere.

Top module: `syl_seq`

## Requirements
- R1: After reset, the current syllable, the syllable index, the word address, the flag register and all dial fields are zero. The word-valid flag and the memory request are low.
- R2: An accepted completion (done_i high, word valid, start_i low, no injection) with index L below 3 loads the syllable at bits [47-12L -: 12] of the word and increments L.
- R3: An accepted completion with L equal to 3 loads bits [11:0], clears L to 0, increments the word address, clears the word-valid flag and raises the memory request for the new address.
- R4: mem_req_o stays high with a steady mem_addr_o until mem_ack_i. At the acknowledge, mem_data_i becomes the program word and the word-valid flag sets.
- R5: done_i is ignored while the word-valid flag is low. The current syllable and L keep their values.
- R6: An accepted completion with irq_i and normal_i both high loads syllable 0x609 and leaves L and the address unchanged.
- R7: The flag register q_o becomes exactly 0x040 on an injection, with bit 6 set and bit 8 clear. It becomes zero on every other accepted completion.
- R8: One cycle after each accepted completion, clr_serial_o pulses high for one cycle. clr_char_o pulses with it only when char_mode_i was high.
- R9: cls_o equals bits [1:0] of the current syllable: 0 literal, 1 operator, 2 operand, 3 descriptor.
- R10: When a syllable completes whose bits [5:0] are 0x2D and whose bits [11:6] are nonzero, g_o takes bits [11:9] and h_o takes bits [8:6]. If bits [11:6] are zero, g_o and h_o keep their values.
- R11: When a syllable completes whose bits [5:0] are 0x31 and whose bits [11:6] are nonzero, k_o takes bits [11:9] and v_o takes bits [8:6].
- R12: When a syllable equal to 0x031 completes, varf_o takes salf_i and salf_clr_o pulses for one cycle. k_o and v_o are unchanged.
- R13: start_i loads the word address from start_addr_i, clears L and launches a fetch. It takes precedence over done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin sequencing at start_addr_i |
| start_addr_i | input | 15 | Starting word address |
| done_i | input | 1 | Current syllable complete |
| irq_i | input | 1 | Interrupt pending |
| normal_i | input | 1 | Processor in normal (not control) state |
| char_mode_i | input | 1 | Processor in character mode |
| salf_i | input | 1 | Current subroutine-state flag |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 15 | Memory read address |
| mem_ack_i | input | 1 | Read data valid |
| mem_data_i | input | 48 | Read program word |
| p_valid_o | output | 1 | Program word valid |
| t_o | output | 12 | Current syllable |
| l_o | output | 2 | Syllable index |
| c_o | output | 15 | Word address |
| cls_o | output | 2 | Major class of current syllable |
| q_o | output | 9 | Per-syllable flag register |
| g_o | output | 3 | Dial A character index |
| h_o | output | 3 | Dial A bit index |
| k_o | output | 3 | Dial B character index |
| v_o | output | 3 | Dial B bit index |
| varf_o | output | 1 | Full-addressing variant flag |
| salf_clr_o | output | 1 | Pulse: clear subroutine-state flag |
| clr_serial_o | output | 1 | Pulse: clear serial character registers |
| clr_char_o | output | 1 | Pulse: clear character-mode registers |

## Verification
The first program word holds one syllable of each class, in a distinct order, so stepping through it shows both the most-significant-first order and the class decode. Its fourth completion also exposes the address step and the refetch. A completion sent while that fetch is still outstanding tells a true stall apart from a dropped or doubled step. The second word places a nonzero dial A, a zero dial A, a nonzero dial B and the zero dial B encoding back to back, which separates field loading from no-op and variant handling. On the third word, an interrupt in normal state, an interrupt in control state and a character-mode completion are tried one after another, so injection is checked against the normal step on the same index and the clear strobes are checked in each mode.

// File: rtl/syl_pkg.sv
// Package: shared widths, syllable class encoding and injected constants
// for the syllable sequencer. Assumes a fixed 12-bit syllable format.
package syl_pkg;
    localparam int SYL_W   = 12;
    localparam int SYL_N   = 4;
    localparam int ADDR_W  = 15;
    localparam int Q_W     = 9;
    localparam int OP_W    = 6;
    localparam int DIAL_W  = 3;

    localparam logic [SYL_W-1:0] INJ_SYL     = 12'h609;
    localparam logic [OP_W-1:0]  OP_DIAL_A   = 6'h2D;
    localparam logic [OP_W-1:0]  OP_DIAL_B   = 6'h31;
    localparam int               Q_HWINT_BIT = 6;

    typedef enum logic [1:0] {
        CLS_LIT  = 2'd0,
        CLS_OPER = 2'd1,
        CLS_OPND = 2'd2,
        CLS_DESC = 2'd3
    } syl_cls_e;
endpackage

// File: rtl/syl_select.sv
// Module: picks one syllable out of a packed program word.
// Assumes slot 0 sits in the most significant bits of the word.
module syl_select #(
    parameter int SYL_W = 12,
    parameter int SYL_N = 4,
    localparam int WORD_W = SYL_W * SYL_N,
    localparam int IDX_W  = (SYL_N > 1) ? $clog2(SYL_N) : 1
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [SYL_W-1:0]  syl_o
);
    logic [SYL_W-1:0] slot [SYL_N];

    // Slice the word into slots, first slot at the top.
    for (genvar i = 0; i < SYL_N; i++) begin : g_slot
        assign slot[i] = word_i[WORD_W-1-i*SYL_W -: SYL_W];
    end

    // Index the slot array.
    always_comb syl_o = slot[idx_i];
endmodule

// File: rtl/syl_decode.sv
// Module: decodes the class and the dial / variant operators of a syllable.
// Assumes the 12-bit format: class in [1:0], minor op in [5:0], variant in [11:6].
module syl_decode
    import syl_pkg::*;
(
    input  logic [SYL_W-1:0]  syl_i,
    output syl_cls_e          cls_o,
    output logic              dial_a_o,
    output logic              dial_b_o,
    output logic              xrt_o,
    output logic [DIAL_W-1:0] hi_o,
    output logic [DIAL_W-1:0] lo_o
);
    logic              var_nz;
    logic [OP_W-1:0]   minor;

    // Split the syllable into its fields.
    always_comb begin
        minor  = syl_i[OP_W-1:0];
        var_nz = |syl_i[SYL_W-1:OP_W];
        cls_o  = syl_cls_e'(syl_i[1:0]);
        hi_o   = syl_i[SYL_W-1 -: DIAL_W];
        lo_o   = syl_i[OP_W+DIAL_W-1:OP_W];
    end

    // Recognise the dial operators and the variant-mode form.
    always_comb begin
        dial_a_o = (minor == OP_DIAL_A) && var_nz;
        dial_b_o = (minor == OP_DIAL_B) && var_nz;
        xrt_o    = (minor == OP_DIAL_B) && !var_nz;
    end
endmodule

// File: rtl/word_fetch.sv
// Module: holds the program word and runs one outstanding memory read.
// Assumes at most one read at a time; a launch restarts the read.
module word_fetch #(
    parameter int WORD_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              ack_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              req_o
);
    // Track request and capture data on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            valid_o <= 1'b0;
            req_o   <= 1'b0;
        end else if (launch_i) begin
            valid_o <= 1'b0;
            req_o   <= 1'b1;
        end else if (req_o && ack_i) begin
            word_o  <= data_i;
            valid_o <= 1'b1;
            req_o   <= 1'b0;
        end
    end
endmodule

// File: rtl/syl_seq.sv
// Module: top of the syllable sequencer. Steps through syllables on each
// completion, refetches when a word is exhausted, injects the store-for-
// interrupt syllable and executes the dial operators.
// Assumes done_i is a one-cycle pulse from the execution stage.
module syl_seq
    import syl_pkg::*;
#(
    parameter int SYL_W_P  = SYL_W,
    parameter int SYL_N_P  = SYL_N,
    parameter int ADDR_W_P = ADDR_W,
    parameter int Q_W_P    = Q_W,
    localparam int WORD_W  = SYL_W_P * SYL_N_P,
    localparam int L_W     = (SYL_N_P > 1) ? $clog2(SYL_N_P) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_W_P-1:0] start_addr_i,
    input  logic                done_i,
    input  logic                irq_i,
    input  logic                normal_i,
    input  logic                char_mode_i,
    input  logic                salf_i,
    output logic                mem_req_o,
    output logic [ADDR_W_P-1:0] mem_addr_o,
    input  logic                mem_ack_i,
    input  logic [WORD_W-1:0]   mem_data_i,
    output logic                p_valid_o,
    output logic [SYL_W_P-1:0]  t_o,
    output logic [L_W-1:0]      l_o,
    output logic [ADDR_W_P-1:0] c_o,
    output logic [1:0]          cls_o,
    output logic [Q_W_P-1:0]    q_o,
    output logic [DIAL_W-1:0]   g_o,
    output logic [DIAL_W-1:0]   h_o,
    output logic [DIAL_W-1:0]   k_o,
    output logic [DIAL_W-1:0]   v_o,
    output logic                varf_o,
    output logic                salf_clr_o,
    output logic                clr_serial_o,
    output logic                clr_char_o
);
    localparam logic [L_W-1:0]   L_LAST = L_W'(SYL_N_P - 1);
    localparam logic [Q_W_P-1:0] Q_INJ  = Q_W_P'(1) << Q_HWINT_BIT;

    logic [WORD_W-1:0]  p_word;
    logic [SYL_W_P-1:0] next_syl;
    logic               accept, inject, wrap, launch;
    syl_cls_e           cls;
    logic               dial_a, dial_b, xrt;
    logic [DIAL_W-1:0]  f_hi, f_lo;

    // Completion acceptance, injection choice and fetch launch.
    always_comb begin
        accept = done_i && p_valid_o && !start_i;
        inject = accept && irq_i && normal_i;
        wrap   = accept && !inject && (l_o == L_LAST);
        launch = start_i || wrap;
    end

    word_fetch #(.WORD_W(WORD_W)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch_i(launch),
        .ack_i   (mem_ack_i),
        .data_i  (mem_data_i),
        .word_o  (p_word),
        .valid_o (p_valid_o),
        .req_o   (mem_req_o)
    );

    syl_select #(.SYL_W(SYL_W_P), .SYL_N(SYL_N_P)) u_sel (
        .word_i(p_word),
        .idx_i (l_o),
        .syl_o (next_syl)
    );

    syl_decode u_dec (
        .syl_i   (t_o),
        .cls_o   (cls),
        .dial_a_o(dial_a),
        .dial_b_o(dial_b),
        .xrt_o   (xrt),
        .hi_o    (f_hi),
        .lo_o    (f_lo)
    );

    // Drive address and class outputs.
    always_comb begin
        mem_addr_o = c_o;
        cls_o      = cls;
    end

    // Syllable stepping, injection and flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_o <= '0;
            l_o <= '0;
            c_o <= '0;
            q_o <= '0;
        end else if (start_i) begin
            c_o <= start_addr_i;
            l_o <= '0;
        end else if (accept) begin
            if (inject) begin
                t_o <= INJ_SYL;
                q_o <= Q_INJ;
            end else begin
                t_o <= next_syl;
                q_o <= '0;
                if (l_o == L_LAST) begin
                    l_o <= '0;
                    c_o <= c_o + 1'b1;
                end else begin
                    l_o <= l_o + 1'b1;
                end
            end
        end
    end

    // Dial fields and variant flag, applied when the syllable completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_o        <= '0;
            h_o        <= '0;
            k_o        <= '0;
            v_o        <= '0;
            varf_o     <= 1'b0;
            salf_clr_o <= 1'b0;
        end else begin
            salf_clr_o <= 1'b0;
            if (accept && dial_a) begin
                g_o <= f_hi;
                h_o <= f_lo;
            end
            if (accept && dial_b) begin
                k_o <= f_hi;
                v_o <= f_lo;
            end
            if (accept && xrt) begin
                varf_o     <= salf_i;
                salf_clr_o <= 1'b1;
            end
        end
    end

    // Per-syllable clear strobes for registers held elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_serial_o <= 1'b0;
            clr_char_o   <= 1'b0;
        end else begin
            clr_serial_o <= accept;
            clr_char_o   <= accept && char_mode_i;
        end
    end
endmodule

// File: rtl/syl_seq_checker.sv
// Module: protocol and sequencing properties for syl_seq, bound to the top.
module syl_seq_checker
    import syl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic              done_i,
    input logic              irq_i,
    input logic              normal_i,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_ack_i,
    input logic              p_valid_o,
    input logic [SYL_W-1:0]  t_o,
    input logic [1:0]        l_o,
    input logic [ADDR_W-1:0] c_o,
    input logic [Q_W-1:0]    q_o
);
    logic acc;
    always_comb acc = done_i && p_valid_o && !start_i;

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !(irq_i && normal_i) && l_o == 2'd3
        |=> l_o == 2'd0 && c_o == ADDR_W'($past(c_o) + 1'b1) && mem_req_o && !p_valid_o);

    assert_req_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !p_valid_o);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i && !start_i |=> mem_req_o && $stable(mem_addr_o));

    assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && !p_valid_o && !start_i |=> $stable(t_o) && $stable(l_o));

    assert_inject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && irq_i && normal_i |=> t_o == INJ_SYL && $stable(l_o) && $stable(c_o));

    assert_qclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !(irq_i && normal_i) |=> q_o == '0);

    assert_qset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && irq_i && normal_i |=> q_o[Q_HWINT_BIT] && !q_o[8]);

    assert_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> mem_req_o && l_o == 2'd0 && mem_addr_o == $past(start_addr_i));
endmodule

bind syl_seq syl_seq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_addr_i(start_addr_i),
    .done_i      (done_i),
    .irq_i       (irq_i),
    .normal_i    (normal_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .p_valid_o   (p_valid_o),
    .t_o         (t_o),
    .l_o         (l_o),
    .c_o         (c_o),
    .q_o         (q_o)
);

// File: tb/syl_seq_tb.sv
`timescale 1ns/1ps
module syl_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [14:0] start_addr_i = '0;
    logic        done_i = 1'b0;
    logic        irq_i = 1'b0;
    logic        normal_i = 1'b0;
    logic        char_mode_i = 1'b0;
    logic        salf_i = 1'b0;
    logic        mem_req_o;
    logic [14:0] mem_addr_o;
    logic        mem_ack_i = 1'b0;
    logic [47:0] mem_data_i = '0;
    logic        p_valid_o;
    logic [11:0] t_o;
    logic [1:0]  l_o;
    logic [14:0] c_o;
    logic [1:0]  cls_o;
    logic [8:0]  q_o;
    logic [2:0]  g_o, h_o, k_o, v_o;
    logic        varf_o, salf_clr_o, clr_serial_o, clr_char_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [47:0] mem [16];
    int ack_cnt = 0;

    always #2.5 clk = ~clk;

    syl_seq u_dut (.*);

    // Memory model: acknowledges a request two negedges after it is seen.
    always @(negedge clk) begin
        mem_ack_i = 1'b0;
        if (mem_req_o) begin
            ack_cnt = ack_cnt + 1;
            if (ack_cnt == 2) begin
                mem_ack_i  = 1'b1;
                mem_data_i = mem[mem_addr_o[3:0]];
                ack_cnt    = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk) done_i = 1'b1;
        @(negedge clk) done_i = 1'b0;
    endtask

    task automatic wait_word();
        for (int i = 0; i < 20 && !p_valid_o; i++) @(negedge clk);
        chk("R4 word valid", 64'(p_valid_o), 64'd1);
    endtask

    task automatic t_reset();
        chk("R1 t", 64'(t_o), 0);
        chk("R1 l", 64'(l_o), 0);
        chk("R1 c", 64'(c_o), 0);
        chk("R1 q", 64'(q_o), 0);
        chk("R1 valid/req", 64'({p_valid_o, mem_req_o}), 0);
        chk("R1 dials", 64'({g_o, h_o, k_o, v_o, varf_o}), 0);
    endtask

    task automatic t_start();
        @(negedge clk) begin start_addr_i = 15'd1; start_i = 1'b1; done_i = 1'b1; end
        @(negedge clk) begin start_i = 1'b0; done_i = 1'b0; end
        chk("R13 req", 64'(mem_req_o), 1);
        chk("R13 addr", 64'(mem_addr_o), 1);
        chk("R13 l", 64'(l_o), 0);
        chk("R13 t unchanged by done", 64'(t_o), 0);
        wait_word();
    endtask

    task automatic t_order();
        step(); chk("R2 t0", 64'(t_o), 64'h0A4); chk("R2 l1", 64'(l_o), 1); chk("R9 lit", 64'(cls_o), 0);
        chk("R8 serial pulse", 64'(clr_serial_o), 1);
        chk("R8 char quiet", 64'(clr_char_o), 0);
        step(); chk("R2 t1", 64'(t_o), 64'h0A6); chk("R9 opnd", 64'(cls_o), 2);
        step(); chk("R2 t2", 64'(t_o), 64'h0A7); chk("R9 desc", 64'(cls_o), 3); chk("R2 l3", 64'(l_o), 3);
        step(); chk("R3 t3", 64'(t_o), 64'h0A5); chk("R9 oper", 64'(cls_o), 1);
        chk("R3 l0", 64'(l_o), 0);
        chk("R3 c", 64'(c_o), 2);
        chk("R3 refetch", 64'({mem_req_o, p_valid_o}), 64'b10);
        chk("R4 addr", 64'(mem_addr_o), 2);
    endtask

    task automatic t_stall();
        step();
        chk("R5 t held", 64'(t_o), 64'h0A5);
        chk("R5 l held", 64'(l_o), 0);
        wait_word();
    endtask

    task automatic t_dials();
        step(); chk("R10 t", 64'(t_o), 64'h9AD);
        step(); chk("R10 g", 64'(g_o), 4); chk("R10 h", 64'(h_o), 6);
        step(); chk("R10 noop g/h", 64'({g_o, h_o}), 64'({3'd4, 3'd6}));
        step(); chk("R11 k", 64'(k_o), 3); chk("R11 v", 64'(v_o), 1);
        chk("R3 c", 64'(c_o), 3);
        wait_word();
        salf_i = 1'b1;
        step();
        chk("R12 varf", 64'(varf_o), 1);
        chk("R12 salf clr", 64'(salf_clr_o), 1);
        chk("R12 k/v kept", 64'({k_o, v_o}), 64'({3'd3, 3'd1}));
        salf_i = 1'b0;
        @(negedge clk);
        chk("R12 pulse ends", 64'(salf_clr_o), 0);
    endtask

    task automatic t_inject();
        irq_i = 1'b1; normal_i = 1'b1;
        step();
        chk("R6 t", 64'(t_o), 64'h609);
        chk("R6 l/c", 64'({l_o, c_o}), 64'({2'd1, 15'd3}));
        chk("R7 q", 64'(q_o), 64'h040);
        irq_i = 1'b0;
        step();
        chk("R2 resume", 64'(t_o), 64'h104);
        chk("R7 q clear", 64'(q_o), 0);
        irq_i = 1'b1; normal_i = 1'b0;
        step();
        chk("R6 control state no inject", 64'(t_o), 64'h108);
        chk("R7 q zero", 64'(q_o), 0);
        irq_i = 1'b0;
    endtask

    task automatic t_charmode();
        char_mode_i = 1'b1;
        step();
        chk("R8 char pulse", 64'({clr_serial_o, clr_char_o}), 64'b11);
        chk("R3 c", 64'(c_o), 4);
        char_mode_i = 1'b0;
        @(negedge clk);
        chk("R8 pulses end", 64'({clr_serial_o, clr_char_o}), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        mem[1] = {12'h0A4, 12'h0A6, 12'h0A7, 12'h0A5};
        mem[2] = {12'h9AD, 12'h02D, 12'h671, 12'h031};
        mem[3] = {12'h100, 12'h104, 12'h108, 12'h10C};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start();
        t_order();
        t_stall();
        t_dials();
        t_inject();
        t_charmode();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule